// File: doc/BRIEF.md
# Breakpoint Clock-Stop Sequencer

This block watches the event strobes a processor core raises each cycle and decides when to stop the core clock so that the scan state can be shifted out. Software sets up to four trigger stages through a small write port. Each stage watches one event type and has a compare value. The event types are:

- a decoded instruction class,
- a count of branch mispredicts,
- a count of cache misses,
- a chosen exception code.

Stages arm one after another. A stage only listens once every earlier stage has matched. The halt is therefore tied to an ordered chain of behaviours rather than to a fixed cycle number.

When a terminal stage matches, the clock-enable output drops on the next edge. It stays low until a debug release pulse arrives. A status field keeps the index of the stage that caused the halt. That field stays readable while the clock is stopped and after the core resumes.

Top module: `bkpt_clkstop`

## Requirements
- R1: After reset, `core_clk_en` is 1, `halt_stage` is 0, `seq_stage` is 0 and the sequencer is disabled.
- R2: A stage whose selector is 0 (instruction class) matches in a cycle where `instr_valid` is 1 and `instr_class` equals bits [3:0] of its compare value. Other classes do not match.
- R3: A stage whose selector is 1 counts `mispredict` pulses, and selector 2 counts `cache_miss` pulses. The count starts at zero when the stage is armed. The stage matches on the pulse that brings the count to its compare value. A compare value of 0 never matches. Pulses of the unselected counter do not advance it.
- R4: A stage whose selector is 3 (exception) matches in a cycle where `exc_valid` is 1 and `exc_code` equals bits [4:0] of its compare value.
- R5: Stage k+1 arms only in the cycle after stage k matches. Events that come before a stage is armed, or in the same cycle that the previous stage matched, are not seen by that stage. Each match advances `seq_stage` by exactly one.
- R6: A match on a terminal stage halts the sequencer. A stage is terminal if its terminal bit is set or it is stage 3. `core_clk_en` stays 1 through the matching cycle and reads 0 from the next clock edge.
- R7: While halted, `core_clk_en` stays 0 and all events are ignored. A `dbg_release` pulse sets `core_clk_en` back to 1 and returns the sequencer to stage 0 with its count cleared. A release in the same cycle as a terminal match wins, and no halt occurs.
- R8: `halt_stage` takes the index of the stage whose match caused the halt. It keeps that value through release until the next halt.
- R9: Configuration writes work as follows:
  - Writing `cfg_addr` 0 to 3 sets stage k. In `cfg_wdata`, bits [15:0] are the compare value, bits [17:16] the selector and bit 18 the terminal flag.
  - Writing `cfg_addr` 4 sets the enable from bit 0 and restarts the sequence at stage 0.
  - While the enable is 0, no event ever halts the core.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running debug clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select (0-3 stage, 4 control) |
| cfg_wdata | input | 19 | Configuration write data |
| instr_valid | input | 1 | A decoded instruction is presented this cycle |
| instr_class | input | 4 | Class of the decoded instruction |
| mispredict | input | 1 | Branch mispredict pulse |
| cache_miss | input | 1 | Cache miss pulse |
| exc_valid | input | 1 | An exception is raised this cycle |
| exc_code | input | 5 | Code of the raised exception |
| dbg_release | input | 1 | Ends a halt and restarts the sequence at stage 0 |
| core_clk_en | output | 1 | Enable for the core clock gate, 0 while halted |
| halt_stage | output | 2 | Sticky index of the stage that caused the last halt |
| seq_stage | output | 2 | Index of the currently armed stage |

## Verification
The hardest case to produce from the ports is a mispredict pulse in the same cycle that the previous stage matches. That pulse must not count toward the next stage, and it only shows up in how many further pulses are needed before `seq_stage` moves. The bench drives an exception match and a mispredict together in one cycle. It then shows that one more mispredict leaves the stage unchanged and a second one advances it. It also drives a release in the same cycle as a terminal match, so the release-over-halt priority can be seen at `core_clk_en`.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  localparam int CNT_W = 16;
  localparam int CLS_W = 4;
  localparam int EXC_W = 5;

  typedef enum logic [1:0] {
    EV_INSTR = 2'd0,
    EV_MISP  = 2'd1,
    EV_MISS  = 2'd2,
    EV_EXC   = 2'd3
  } ev_sel_e;

  typedef struct packed {
    logic             term;
    ev_sel_e          sel;
    logic [CNT_W-1:0] cmp;
  } stage_cfg_t;

  localparam int CFG_W = $bits(stage_cfg_t);

  // True when one more event brings the running count to the target.
  // A target of zero can never be reached this way.
  function automatic logic count_reaches(input logic [CNT_W-1:0] cnt,
                                         input logic [CNT_W-1:0] target);
    return ({1'b0, cnt} + (CNT_W+1)'(1)) == {1'b0, target};
  endfunction

  function automatic stage_cfg_t decode_stage(input logic [CFG_W-1:0] d);
    stage_cfg_t c;
    c.cmp  = d[CNT_W-1:0];
    c.sel  = ev_sel_e'(d[CNT_W+1:CNT_W]);
    c.term = d[CNT_W+2];
    return c;
  endfunction
endpackage

// File: rtl/bkpt_cfg_regs.sv
module bkpt_cfg_regs
  import bkpt_pkg::*;
#(
  parameter int NSTG   = 4,
  parameter int ADDR_W = $clog2(NSTG + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [CFG_W-1:0]            wdata,
  output stage_cfg_t [NSTG-1:0]       cfg,
  output logic                        enable,
  output logic                        ctl_wr
);
  assign ctl_wr = we && (addr == ADDR_W'(NSTG));

  for (genvar k = 0; k < NSTG; k++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cfg[k] <= '0;
      else if (we && addr == ADDR_W'(k))
        cfg[k] <= decode_stage(wdata);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      enable <= 1'b0;
    else if (ctl_wr) enable <= wdata[0];
  end
endmodule

// File: rtl/bkpt_event_match.sv
module bkpt_event_match
  import bkpt_pkg::*;
(
  input  ev_sel_e          sel,
  input  logic [CNT_W-1:0] cmp,
  input  logic [CNT_W-1:0] cnt,
  input  logic             instr_valid,
  input  logic [CLS_W-1:0] instr_class,
  input  logic             mispredict,
  input  logic             cache_miss,
  input  logic             exc_valid,
  input  logic [EXC_W-1:0] exc_code,
  output logic             cnt_ev,
  output logic             hit
);
  always_comb begin
    cnt_ev = 1'b0;
    hit    = 1'b0;
    unique case (sel)
      EV_INSTR: hit = instr_valid && (instr_class == cmp[CLS_W-1:0]);
      EV_MISP: begin
        cnt_ev = mispredict;
        hit    = mispredict && count_reaches(cnt, cmp);
      end
      EV_MISS: begin
        cnt_ev = cache_miss;
        hit    = cache_miss && count_reaches(cnt, cmp);
      end
      EV_EXC:   hit = exc_valid && (exc_code == cmp[EXC_W-1:0]);
      default:  hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/bkpt_seq.sv
module bkpt_seq
  import bkpt_pkg::*;
#(
  parameter int NSTG  = 4,
  parameter int STG_W = $clog2(NSTG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             restart_cfg,
  input  logic             release_i,
  input  logic             hit,
  input  logic             cnt_ev,
  input  logic             term,
  output logic [STG_W-1:0] stage,
  output logic [CNT_W-1:0] cnt,
  output logic             halted,
  output logic [STG_W-1:0] halt_stage,
  output logic             fire,
  output logic             adv
);
  logic running;
  logic last_stage;

  assign running    = enable && !halted && !release_i && !restart_cfg;
  assign last_stage = term || (stage == STG_W'(NSTG - 1));
  assign fire       = running && hit && last_stage;
  assign adv        = running && hit && !last_stage;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halted     <= 1'b0;
      halt_stage <= '0;
    end else if (release_i) begin
      halted     <= 1'b0;
    end else if (fire) begin
      halted     <= 1'b1;
      halt_stage <= stage;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage <= '0;
      cnt   <= '0;
    end else if (release_i || restart_cfg) begin
      stage <= '0;
      cnt   <= '0;
    end else if (adv) begin
      stage <= stage + STG_W'(1);
      cnt   <= '0;
    end else if (running && cnt_ev) begin
      cnt   <= cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/bkpt_clkstop.sv
module bkpt_clkstop
  import bkpt_pkg::*;
#(
  parameter int NSTG   = 4,
  parameter int STG_W  = $clog2(NSTG),
  parameter int ADDR_W = $clog2(NSTG + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              instr_valid,
  input  logic [CLS_W-1:0]  instr_class,
  input  logic              mispredict,
  input  logic              cache_miss,
  input  logic              exc_valid,
  input  logic [EXC_W-1:0]  exc_code,
  input  logic              dbg_release,
  output logic              core_clk_en,
  output logic [STG_W-1:0]  halt_stage,
  output logic [STG_W-1:0]  seq_stage
);
  stage_cfg_t [NSTG-1:0] stage_cfg;
  stage_cfg_t            cur_cfg;
  logic                  seq_enable;
  logic                  ctl_wr;
  logic [CNT_W-1:0]      ev_cnt;
  logic                  ev_hit;
  logic                  ev_counted;
  logic                  halted;
  logic                  halt_fire;
  logic                  stage_adv;

  bkpt_cfg_regs #(.NSTG(NSTG), .ADDR_W(ADDR_W)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (cfg_we),
    .addr   (cfg_addr),
    .wdata  (cfg_wdata),
    .cfg    (stage_cfg),
    .enable (seq_enable),
    .ctl_wr (ctl_wr)
  );

  assign cur_cfg = stage_cfg[seq_stage];

  bkpt_event_match u_match (
    .sel         (cur_cfg.sel),
    .cmp         (cur_cfg.cmp),
    .cnt         (ev_cnt),
    .instr_valid (instr_valid),
    .instr_class (instr_class),
    .mispredict  (mispredict),
    .cache_miss  (cache_miss),
    .exc_valid   (exc_valid),
    .exc_code    (exc_code),
    .cnt_ev      (ev_counted),
    .hit         (ev_hit)
  );

  bkpt_seq #(.NSTG(NSTG), .STG_W(STG_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (seq_enable),
    .restart_cfg (ctl_wr),
    .release_i   (dbg_release),
    .hit         (ev_hit),
    .cnt_ev      (ev_counted),
    .term        (cur_cfg.term),
    .stage       (seq_stage),
    .cnt         (ev_cnt),
    .halted      (halted),
    .halt_stage  (halt_stage),
    .fire        (halt_fire),
    .adv         (stage_adv)
  );

  assign core_clk_en = !halted;
endmodule

// File: rtl/bkpt_clkstop_chk.sv
module bkpt_clkstop_chk #(
  parameter int STG_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dbg_release,
  input logic             core_clk_en,
  input logic [STG_W-1:0] seq_stage,
  input logic [STG_W-1:0] halt_stage,
  input logic             halt_fire,
  input logic             stage_adv,
  input logic             seq_enable
);
  a_r6_stop_after_fire: assert property (@(posedge clk) disable iff (!rst_n)
    halt_fire |=> !core_clk_en);

  a_r6_fall_needs_fire: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_clk_en) |-> $past(halt_fire));

  a_r7_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_clk_en && !dbg_release) |=> !core_clk_en);

  a_r7_release_restores: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_release |=> (core_clk_en && seq_stage == '0));

  a_r5_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_adv && !dbg_release) |=> (seq_stage == STG_W'($past(seq_stage) + 1'b1)));

  a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({halt_fire, stage_adv}));

  a_r8_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !halt_fire |=> $stable(halt_stage));

  a_r9_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_enable |-> !(halt_fire || stage_adv));
endmodule

bind bkpt_clkstop bkpt_clkstop_chk #(.STG_W(STG_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .dbg_release (dbg_release),
  .core_clk_en (core_clk_en),
  .seq_stage   (seq_stage),
  .halt_stage  (halt_stage),
  .halt_fire   (halt_fire),
  .stage_adv   (stage_adv),
  .seq_enable  (seq_enable)
);

// File: tb/tb_bkpt_clkstop.sv
module tb_bkpt_clkstop;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_addr;
  logic [18:0] cfg_wdata;
  logic        instr_valid;
  logic [3:0]  instr_class;
  logic        mispredict;
  logic        cache_miss;
  logic        exc_valid;
  logic [4:0]  exc_code;
  logic        dbg_release;
  logic        core_clk_en;
  logic [1:0]  halt_stage;
  logic [1:0]  seq_stage;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  bkpt_clkstop dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .instr_valid(instr_valid), .instr_class(instr_class),
    .mispredict(mispredict), .cache_miss(cache_miss), .exc_valid(exc_valid),
    .exc_code(exc_code), .dbg_release(dbg_release), .core_clk_en(core_clk_en),
    .halt_stage(halt_stage), .seq_stage(seq_stage)
  );

  // {selector[1:0], compare[15:0], event count[3:0], wrong-event flag, expect halt}
  localparam logic [23:0] VECS [10] = '{
    {2'd0, 16'd5, 4'd1, 1'b0, 1'b1},
    {2'd0, 16'd5, 4'd3, 1'b1, 1'b0},
    {2'd1, 16'd3, 4'd2, 1'b0, 1'b0},
    {2'd1, 16'd3, 4'd3, 1'b0, 1'b1},
    {2'd2, 16'd1, 4'd1, 1'b0, 1'b1},
    {2'd2, 16'd4, 4'd3, 1'b0, 1'b0},
    {2'd3, 16'd7, 4'd1, 1'b0, 1'b1},
    {2'd3, 16'd7, 4'd2, 1'b1, 1'b0},
    {2'd1, 16'd0, 4'd5, 1'b0, 1'b0},
    {2'd2, 16'd6, 4'd6, 1'b1, 1'b0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_ev();
    instr_valid = 0; instr_class = 0; mispredict = 0; cache_miss = 0;
    exc_valid = 0; exc_code = 0; dbg_release = 0; cfg_we = 0;
  endtask

  task automatic cfg_write(input logic [2:0] a, input logic [18:0] d);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic set_ev(input logic [1:0] kind, input logic [15:0] val);
    case (kind)
      2'd0: begin instr_valid = 1; instr_class = val[3:0]; end
      2'd1: mispredict = 1;
      2'd2: cache_miss = 1;
      default: begin exc_valid = 1; exc_code = val[4:0]; end
    endcase
  endtask

  task automatic ev(input logic [1:0] kind, input logic [15:0] val);
    set_ev(kind, val);
    @(negedge clk);
    clear_ev();
  endtask

  task automatic release_pulse();
    dbg_release = 1;
    @(negedge clk);
    dbg_release = 0;
  endtask

  function automatic string sel_tag(input logic [1:0] s);
    case (s)
      2'd0: return "R2";
      2'd3: return "R4";
      default: return "R3";
    endcase
  endfunction

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    clear_ev();
    cfg_addr = 0; cfg_wdata = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 clk_en", core_clk_en, 1);
    chk("R1 halt_stage", halt_stage, 0);
    chk("R1 seq_stage", seq_stage, 0);
    ev(2'd0, 16'd0);
    chk("R1 disabled at reset", core_clk_en, 1);

    // table of single-stage scenarios (R2, R3, R4)
    for (int i = 0; i < 10; i++) begin
      logic [1:0]  s;
      logic [15:0] c;
      logic [3:0]  n;
      logic        wr;
      logic        ex;
      {s, c, n, wr, ex} = VECS[i];
      release_pulse();
      cfg_write(3'd0, {1'b1, s, c});
      cfg_write(3'd4, 19'd1);
      for (int k = 0; k < int'(n); k++) begin
        if (!wr) ev(s, c);
        else if (s == 2'd1) ev(2'd2, c);
        else if (s == 2'd2) ev(2'd1, c);
        else ev(s, c + 16'd1);
        @(negedge clk);
      end
      chk($sformatf("%s vector %0d clk_en", sel_tag(s), i), core_clk_en, ex ? 0 : 1);
      if (ex) chk("R8 single-stage index", halt_stage, 0);
    end

    // R9: disabled sequencer ignores a matching event
    release_pulse();
    cfg_write(3'd0, {1'b1, 2'd0, 16'd2});
    cfg_write(3'd4, 19'd0);
    ev(2'd0, 16'd2);
    chk("R9 disabled no halt", core_clk_en, 1);

    // R5 ordered chain: exc 3 -> 2 mispredicts -> instr class 9 (terminal)
    cfg_write(3'd0, {1'b0, 2'd3, 16'd3});
    cfg_write(3'd1, {1'b0, 2'd1, 16'd2});
    cfg_write(3'd2, {1'b1, 2'd0, 16'd9});
    cfg_write(3'd4, 19'd1);
    ev(2'd1, 0);
    ev(2'd1, 0);
    ev(2'd0, 16'd9);
    chk("R5 later stages not armed", seq_stage, 0);
    chk("R5 early terminal event ignored", core_clk_en, 1);
    exc_valid = 1; exc_code = 5'd3; mispredict = 1;
    @(negedge clk);
    clear_ev();
    chk("R5 advance to stage 1", seq_stage, 1);
    ev(2'd1, 0);
    chk("R5 same-cycle pulse not counted", seq_stage, 1);
    ev(2'd1, 0);
    chk("R5 count complete advance", seq_stage, 2);
    set_ev(2'd0, 16'd9);
    #1;
    chk("R6 clk_en high in matching cycle", core_clk_en, 1);
    @(negedge clk);
    clear_ev();
    chk("R6 clk_en low after edge", core_clk_en, 0);
    chk("R8 halt index 2", halt_stage, 2);

    // R7 hold while halted
    ev(2'd0, 16'd9);
    ev(2'd1, 0);
    repeat (3) @(negedge clk);
    chk("R7 stays low", core_clk_en, 0);
    chk("R7 events ignored while halted", seq_stage, 2);
    release_pulse();
    chk("R7 release restores clk_en", core_clk_en, 1);
    chk("R7 release to stage 0", seq_stage, 0);
    chk("R8 status sticky after release", halt_stage, 2);

    // R6 terminal by position: stage 3
    cfg_write(3'd0, {1'b0, 2'd0, 16'd0});
    cfg_write(3'd1, {1'b0, 2'd0, 16'd1});
    cfg_write(3'd2, {1'b0, 2'd0, 16'd2});
    cfg_write(3'd3, {1'b0, 2'd0, 16'd3});
    cfg_write(3'd4, 19'd1);
    for (int k = 0; k < 3; k++) ev(2'd0, 16'(k));
    chk("R6 non-terminal no halt", core_clk_en, 1);
    chk("R5 at stage 3", seq_stage, 3);
    ev(2'd0, 16'd3);
    chk("R6 last stage halts", core_clk_en, 0);
    chk("R8 halt index 3", halt_stage, 3);

    // R7 release beats a same-cycle terminal match
    release_pulse();
    cfg_write(3'd0, {1'b1, 2'd0, 16'd4});
    cfg_write(3'd4, 19'd1);
    instr_valid = 1; instr_class = 4'd4; dbg_release = 1;
    @(negedge clk);
    clear_ev();
    chk("R7 release wins over match", core_clk_en, 1);
    ev(2'd0, 16'd4);
    chk("R7 later match halts", core_clk_en, 0);
    chk("R8 halt index 0", halt_stage, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule